// File: doc/BRIEF.md
# Packet Peripheral Register Front-End

This block is the bus side of a packet transport peripheral. It sits on an APB slave port and decodes a 16-byte window of four 32-bit words: a control/status word, a data port, a length port and one reserved word. Software pushes a transmit packet word by word into the data port and then commits it by writing its byte length to the length port. It drains a received packet by reading the length port and then as many data words as that length needs. Data and length accesses become single-cycle strobes towards separate transmit and receive engines. Those engines hold the packet buffers and are not part of this block.

The control/status word works indirectly. Writing zero to it raises a one-cycle soft reset for both engines and clears every counter and selector in this block. Writing a code from 1 to 7 selects one statistic, and later reads of the same word return that statistic's live value. Six of the statistics are event counters kept here. The seventh is the free transmit space, which the transmit engine reports.

The receive interrupt rises when a packet arrives and no drain session is open. It drops at the next length read. A length read that returns a non-zero value opens a drain session, and arrivals during the session do not raise the interrupt again. A length read that returns zero closes the session.

Top module: `pkt_apb_regs`

## Requirements
- R1: Word decode uses paddr bits [3:2]: 0 = control/status, 1 = data, 2 = length, 3 = reserved. The reserved word reads as zero, and writes to it cause no strobe, no soft reset and no change to any counter.
- R2: A write of value 0 to the control/status word drives sreset_o high for exactly that access cycle. After that edge all six counters read zero, the selector is cleared and the interrupt is low.
- R3: After a write of code c to control/status, reads of that word return: c=1 tx_free_bytes_i, 2 TX queued, 3 TX sent, 4 TX dropped, 5 RX queued, 6 RX received, 7 RX dropped (zero-extended).
- R4: The selector keeps its value until the next control/status write, so repeated reads return the live count. A write of a value above 7 leaves no valid selector, and reads then return zero, as they do after reset.
- R5: A data write pulses tx_wr_o for one cycle with tx_wdata_o equal to the written word. A data read pulses rx_rd_o for one cycle and returns rx_rdata_i.
- R6: A length write pulses tx_commit_o with tx_len_o equal to the low LEN_W bits of the written word. A length read returns rx_len_i zero-extended and pulses no engine strobe.
- R7: TX queued rises by one on each commit and falls by one on tx_sent_i or tx_drop_i. RX queued rises by one on rx_recv_i and falls by one on rx_pop_i. TX sent, TX dropped, RX received and RX dropped count their own pulses. Counters saturate and do not wrap.
- R8: rx_irq_o goes high the cycle after an rx_recv_i pulse when no drain session is open. It stays high until a length read.
- R9: A length read that returns non-zero opens a drain session, and rx_recv_i during the session does not raise rx_irq_o. A length read that returns zero closes the session.
- R10: Every access completes in its access phase: pready_o is 1 and pslverr_o is 0.
- R11: A setup-phase cycle (psel_i high, penable_i low) produces no strobe and no soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write |
| paddr_i | input | ADDR_W | Byte offset inside the window |
| pwdata_i | input | DATA_W | Write data |
| prdata_o | output | DATA_W | Read data |
| pready_o | output | 1 | Ready, always high |
| pslverr_o | output | 1 | Error, always low |
| sreset_o | output | 1 | Soft reset pulse to the engines |
| tx_wr_o | output | 1 | Transmit word strobe |
| tx_wdata_o | output | DATA_W | Transmit word |
| tx_commit_o | output | 1 | Transmit packet commit strobe |
| tx_len_o | output | LEN_W | Committed packet length in bytes |
| tx_free_bytes_i | input | DATA_W | Free transmit buffer space in bytes |
| tx_sent_i | input | 1 | One packet sent |
| tx_drop_i | input | 1 | One queued packet dropped |
| rx_rd_o | output | 1 | Receive word pop strobe |
| rx_rdata_i | input | DATA_W | Head receive word |
| rx_len_i | input | LEN_W | Length of head receive packet, 0 if none |
| rx_recv_i | input | 1 | One packet received and queued |
| rx_drop_i | input | 1 | One incoming packet dropped |
| rx_pop_i | input | 1 | One packet fully drained |
| rx_irq_o | output | 1 | Receive interrupt |

## Verification
The assertions rely on the APB master never holding the access phase for two cycles in a row, because with a ready that is always high each transfer is setup followed by one access. Single-cycle strobes and the soft-reset pulse depend on that. They also rely on the engines giving each event pulse as a single-cycle strobe. The bench drives every transfer through one task that always performs setup, then one access, then idle. It raises every engine event for exactly one clock between falling edges, so the inputs always follow those assumptions.

// File: rtl/pkt_regs_pkg.sv
package pkt_regs_pkg;
  localparam int N_STAT = 6;

  typedef enum logic [1:0] {
    W_CTRL = 2'd0,
    W_DATA = 2'd1,
    W_LEN  = 2'd2,
    W_RSVD = 2'd3
  } word_e;

  typedef enum logic [2:0] {
    SEL_NONE    = 3'd0,
    SEL_TX_FREE = 3'd1,
    SEL_TX_Q    = 3'd2,
    SEL_TX_SENT = 3'd3,
    SEL_TX_DROP = 3'd4,
    SEL_RX_Q    = 3'd5,
    SEL_RX_RECV = 3'd6,
    SEL_RX_DROP = 3'd7
  } stat_sel_e;

  // counter slots
  localparam int C_TX_Q    = 0;
  localparam int C_TX_SENT = 1;
  localparam int C_TX_DROP = 2;
  localparam int C_RX_Q    = 3;
  localparam int C_RX_RECV = 4;
  localparam int C_RX_DROP = 5;
endpackage

// File: rtl/pkt_apb_decode.sv
module pkt_apb_decode
  import pkt_regs_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  output logic              wr_ctrl_o,
  output logic              wr_data_o,
  output logic              wr_len_o,
  output logic              rd_ctrl_o,
  output logic              rd_data_o,
  output logic              rd_len_o
);
  logic  access;
  word_e word;
  logic  unused_addr;

  assign access      = psel_i & penable_i;
  assign word        = word_e'(paddr_i[3:2]);
  assign unused_addr = ^{paddr_i[1:0], paddr_i[ADDR_W-1:2]};

  always_comb begin
    wr_ctrl_o = 1'b0; wr_data_o = 1'b0; wr_len_o = 1'b0;
    rd_ctrl_o = 1'b0; rd_data_o = 1'b0; rd_len_o = 1'b0;
    if (access) begin
      unique case (word)
        W_CTRL: if (pwrite_i) wr_ctrl_o = 1'b1; else rd_ctrl_o = 1'b1;
        W_DATA: if (pwrite_i) wr_data_o = 1'b1; else rd_data_o = 1'b1;
        W_LEN:  if (pwrite_i) wr_len_o  = 1'b1; else rd_len_o  = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pkt_event_ctr.sv
module pkt_event_ctr #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_o <= '0;
    else if (clr_i)                       cnt_o <= '0;
    else if (inc_i && !dec_i && cnt_o != MAX) cnt_o <= cnt_o + 1'b1;
    else if (dec_i && !inc_i && cnt_o != '0)  cnt_o <= cnt_o - 1'b1;
  end

  assert_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
  assert_no_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && cnt_o == MAX) |=> cnt_o != '0);
endmodule

// File: rtl/pkt_rx_irq.sv
module pkt_rx_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic recv_i,
  input  logic len_rd_i,
  input  logic len_nz_i,
  output logic irq_o
);
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      irq_o  <= 1'b0;
    end else if (clr_i) begin
      busy_q <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      if (len_rd_i) busy_q <= len_nz_i;
      // a new arrival outside a session wins over an acknowledge
      if (recv_i && !busy_q) irq_o <= 1'b1;
      else if (len_rd_i)     irq_o <= 1'b0;
    end
  end

  assert_irq_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_rd_i && !recv_i) |=> !irq_o);
  assert_quiet_session_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !irq_o && !len_rd_i) |=> !irq_o);
endmodule

// File: rtl/pkt_apb_regs.sv
module pkt_apb_regs
  import pkt_regs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  output logic              sreset_o,
  output logic              tx_wr_o,
  output logic [DATA_W-1:0] tx_wdata_o,
  output logic              tx_commit_o,
  output logic [LEN_W-1:0]  tx_len_o,
  input  logic [DATA_W-1:0] tx_free_bytes_i,
  input  logic              tx_sent_i,
  input  logic              tx_drop_i,
  output logic              rx_rd_o,
  input  logic [DATA_W-1:0] rx_rdata_i,
  input  logic [LEN_W-1:0]  rx_len_i,
  input  logic              rx_recv_i,
  input  logic              rx_drop_i,
  input  logic              rx_pop_i,
  output logic              rx_irq_o
);
  logic wr_ctrl, wr_data, wr_len, rd_ctrl, rd_data, rd_len;
  logic sel_valid;
  stat_sel_e sel_q;
  logic [N_STAT-1:0] ev_inc, ev_dec;
  logic [CNT_W-1:0]  cnt [N_STAT];
  logic [DATA_W-1:0] stat_val;

  pkt_apb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .psel_i, .penable_i, .pwrite_i, .paddr_i,
    .wr_ctrl_o(wr_ctrl), .wr_data_o(wr_data), .wr_len_o(wr_len),
    .rd_ctrl_o(rd_ctrl), .rd_data_o(rd_data), .rd_len_o(rd_len)
  );

  assign pready_o    = 1'b1;
  assign pslverr_o   = 1'b0;
  assign sreset_o    = wr_ctrl & (pwdata_i == '0);
  assign tx_wr_o     = wr_data;
  assign tx_wdata_o  = pwdata_i;
  assign tx_commit_o = wr_len;
  assign tx_len_o    = pwdata_i[LEN_W-1:0];
  assign rx_rd_o     = rd_data;

  assign sel_valid = (pwdata_i != '0) && (pwdata_i <= DATA_W'(7));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_q <= SEL_NONE;
    else if (wr_ctrl) sel_q <= sel_valid ? stat_sel_e'(pwdata_i[2:0]) : SEL_NONE;
  end

  always_comb begin
    ev_inc = '0;
    ev_dec = '0;
    ev_inc[C_TX_Q]    = wr_len;
    ev_dec[C_TX_Q]    = tx_sent_i | tx_drop_i;
    ev_inc[C_TX_SENT] = tx_sent_i;
    ev_inc[C_TX_DROP] = tx_drop_i;
    ev_inc[C_RX_Q]    = rx_recv_i;
    ev_dec[C_RX_Q]    = rx_pop_i;
    ev_inc[C_RX_RECV] = rx_recv_i;
    ev_inc[C_RX_DROP] = rx_drop_i;
  end

  for (genvar i = 0; i < N_STAT; i++) begin : g_ctr
    pkt_event_ctr #(.W(CNT_W)) u_ctr (
      .clk_i, .rst_ni, .clr_i(sreset_o),
      .inc_i(ev_inc[i]), .dec_i(ev_dec[i]), .cnt_o(cnt[i])
    );
  end

  always_comb begin
    unique case (sel_q)
      SEL_TX_FREE: stat_val = tx_free_bytes_i;
      SEL_TX_Q:    stat_val = DATA_W'(cnt[C_TX_Q]);
      SEL_TX_SENT: stat_val = DATA_W'(cnt[C_TX_SENT]);
      SEL_TX_DROP: stat_val = DATA_W'(cnt[C_TX_DROP]);
      SEL_RX_Q:    stat_val = DATA_W'(cnt[C_RX_Q]);
      SEL_RX_RECV: stat_val = DATA_W'(cnt[C_RX_RECV]);
      SEL_RX_DROP: stat_val = DATA_W'(cnt[C_RX_DROP]);
      default:     stat_val = '0;
    endcase
  end

  always_comb begin
    prdata_o = '0;
    if (rd_ctrl)      prdata_o = stat_val;
    else if (rd_data) prdata_o = rx_rdata_i;
    else if (rd_len)  prdata_o = DATA_W'(rx_len_i);
  end

  pkt_rx_irq u_irq (
    .clk_i, .rst_ni, .clr_i(sreset_o), .recv_i(rx_recv_i),
    .len_rd_i(rd_len), .len_nz_i(rx_len_i != '0), .irq_o(rx_irq_o)
  );

  assert_sreset_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sreset_o |=> !sreset_o);
  assert_rx_pop_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rd_o |=> !rx_rd_o);
  assert_sel_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ctrl |=> $stable(sel_q));
  assert_setup_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && !penable_i) |-> !(sreset_o || tx_wr_o || tx_commit_o || rx_rd_o));
endmodule

// File: tb/pkt_apb_regs_test.sv
module pkt_apb_regs_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        psel_i = 0, penable_i = 0, pwrite_i = 0;
  logic [3:0]  paddr_i = '0;
  logic [31:0] pwdata_i = '0;
  logic [31:0] prdata_o;
  logic        pready_o, pslverr_o, sreset_o;
  logic        tx_wr_o, tx_commit_o, rx_rd_o, rx_irq_o;
  logic [31:0] tx_wdata_o;
  logic [15:0] tx_len_o;
  logic [31:0] tx_free_bytes_i = 32'd1500;
  logic        tx_sent_i = 0, tx_drop_i = 0;
  logic [31:0] rx_rdata_i = '0;
  logic [15:0] rx_len_i = '0;
  logic        rx_recv_i = 0, rx_drop_i = 0, rx_pop_i = 0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic s_sreset, s_txwr, s_commit, s_rxrd, s_ready, s_err;
  logic [31:0] s_wdata, rd;
  logic [15:0] s_len;

  always #2.5 clk_i = ~clk_i;

  pkt_apb_regs uut (.*);

  // {selector code, expected value}
  localparam logic [35:0] STAT_TBL [9] = '{
    {4'd1, 32'd1500}, {4'd2, 32'd1}, {4'd3, 32'd1}, {4'd4, 32'd1},
    {4'd5, 32'd3},    {4'd6, 32'd4}, {4'd7, 32'd2}, {4'd9, 32'd0},
    {4'd15, 32'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    psel_i = 1; penable_i = 0; pwrite_i = wr; paddr_i = a; pwdata_i = d;
    @(negedge clk_i);
    penable_i = 1;
    #1;
    rd = prdata_o; s_sreset = sreset_o; s_txwr = tx_wr_o; s_commit = tx_commit_o;
    s_rxrd = rx_rd_o; s_ready = pready_o; s_err = pslverr_o;
    s_wdata = tx_wdata_o; s_len = tx_len_o;
    @(negedge clk_i);
    psel_i = 0; penable_i = 0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk_i);
    case (which)
      0: tx_sent_i = 1; 1: tx_drop_i = 1; 2: rx_recv_i = 1;
      3: rx_drop_i = 1; default: rx_pop_i = 1;
    endcase
    @(negedge clk_i);
    {tx_sent_i, tx_drop_i, rx_recv_i, rx_drop_i, rx_pop_i} = '0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // reset state
    chk("R8 irq after reset", rx_irq_o, 0);
    xfer(0, 4'h0, 0);
    chk("R4 status after reset", rd, 0);
    chk("R10 ready", s_ready, 1);
    chk("R10 no error", s_err, 0);

    // R1 reserved word
    xfer(0, 4'hC, 0);
    chk("R1 reserved read", rd, 0);
    xfer(1, 4'hC, 0);
    chk("R1 reserved write strobes", {s_sreset, s_txwr, s_commit, s_rxrd}, 0);

    // R5 data port
    xfer(1, 4'h4, 32'hA5A5_0102);
    chk("R5 tx strobe", s_txwr, 1);
    chk("R5 tx word", s_wdata, 32'hA5A5_0102);
    rx_rdata_i = 32'hCAFE_F00D;
    xfer(0, 4'h4, 0);
    chk("R5 rx strobe", s_rxrd, 1);
    chk("R5 rx word", rd, 32'hCAFE_F00D);

    // R11 setup phase alone
    @(negedge clk_i);
    psel_i = 1; penable_i = 0; pwrite_i = 1; paddr_i = 4'h4; pwdata_i = 0;
    #1;
    chk("R11 setup no strobe", {tx_wr_o, tx_commit_o, rx_rd_o, sreset_o}, 0);
    @(negedge clk_i);
    psel_i = 0;

    // R8 / R9 interrupt and drain session
    pulse(2);
    chk("R8 irq on arrival", rx_irq_o, 1);
    rx_len_i = 16'd60;
    xfer(0, 4'h8, 0);
    chk("R6 length read", rd, 60);
    chk("R6 length read no pop", s_rxrd, 0);
    chk("R8 irq cleared by length read", rx_irq_o, 0);
    pulse(2);
    chk("R9 no irq inside session", rx_irq_o, 0);
    rx_len_i = 0;
    xfer(0, 4'h8, 0);
    chk("R9 zero length closes", rd, 0);
    pulse(2);
    chk("R9 irq after session closed", rx_irq_o, 1);

    // R2 soft reset
    xfer(1, 4'h0, 6);
    xfer(0, 4'h0, 0);
    chk("R3 rx received before reset", rd, 3);
    xfer(1, 4'h0, 0);
    chk("R2 soft reset pulse", s_sreset, 1);
    chk("R2 irq cleared", rx_irq_o, 0);
    xfer(0, 4'h0, 0);
    chk("R2 selector cleared", rd, 0);
    xfer(1, 4'h0, 6);
    xfer(0, 4'h0, 0);
    chk("R2 counter cleared", rd, 0);

    // R6 / R7 build counts
    xfer(1, 4'h8, 32'hFFFF_003C);
    chk("R6 commit strobe", s_commit, 1);
    chk("R6 commit length", s_len, 16'h003C);
    xfer(1, 4'h8, 40);
    xfer(1, 4'h8, 20);
    pulse(0); pulse(1);
    pulse(2); pulse(2); pulse(2); pulse(2);
    pulse(4); pulse(3); pulse(3);

    // R3 / R7 table walk
    foreach (STAT_TBL[i]) begin
      xfer(1, 4'h0, {28'd0, STAT_TBL[i][35:32]});
      xfer(0, 4'h0, 0);
      chk($sformatf("R3 R7 selector %0d", STAT_TBL[i][35:32]), rd, STAT_TBL[i][31:0]);
    end

    // R4 selector hold with live value
    xfer(1, 4'h0, 6);
    xfer(0, 4'h0, 0);
    chk("R4 first read", rd, 4);
    pulse(2);
    xfer(0, 4'h0, 0);
    chk("R4 live reread", rd, 5);
    // R1 zero written to reserved word does not reset
    xfer(1, 4'hC, 0);
    chk("R1 reserved zero no reset", s_sreset, 0);
    xfer(0, 4'h0, 0);
    chk("R1 counters kept", rd, 5);

    // R7 saturation at zero: extra pop with RX queued at 4
    repeat (5) pulse(4);
    xfer(1, 4'h0, 5);
    xfer(0, 4'h0, 0);
    chk("R7 rx queued floor", rd, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule